// File: doc/BRIEF.md
# Framed Serial Converter Write Receiver

This block receives the write port of a 12-bit converter. A host pulls an active-low frame strobe, then clocks sixteen data bits most significant first on the falling edges of a serial clock. When the sixteenth bit arrives, the block loads a 12-bit converter code and a 2-bit power-down mode field into its held output register. It marks the load with a pulse that lasts one system clock. The two leading bits of the word are reserved and are dropped.

The block runs on a system clock that is much faster than the serial clock. The strobe, serial clock and data lines each pass through a synchronizer chain, and the edges are found from the synchronized copies. If the strobe is released before the sixteenth bit, the frame is cancelled and the held register keeps its old value. Once a frame is complete, further serial clock edges are ignored until the strobe has gone high and then low again.

Top module: `serdac_frame_rx`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `load_o` is 0 and `code_o` and `mode_o` are all zeros.
- R2: Bits arrive most significant first. Of the 16-bit word, bits 11:0 appear on `code_o`, bits 13:12 appear on `mode_o`, and bits 15:14 are discarded.
- R3: Each bit is taken from `sdin` at a falling edge of `sclk`. A change of `sdin` while `sclk` is low or at its rising edge does not alter the captured word.
- R4: Serial clock edges seen while `frame_n` is high, before the frame falls, capture nothing and cause no load.
- R5: No load occurs after 15 falling edges of a frame. The load occurs after the 16th falling edge.
- R6: Each completed frame produces exactly one `load_o` pulse, and the pulse is one system clock long.
- R7: If `frame_n` rises before the 16th falling edge, the frame is cancelled: no load occurs and the outputs keep their previous values.
- R8: After the 16th bit, further `sclk` falling edges in the same frame are ignored: no second load occurs and the outputs keep the loaded word.
- R9: After a cancelled frame, the next falling edge of `frame_n` starts a fresh count of 16 bits.
- R10: `code_o` and `mode_o` change only in a cycle where `load_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversampling the serial lines |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_n | input | 1 | Active-low frame strobe |
| sclk | input | 1 | Serial clock; data is taken on its falling edge |
| sdin | input | 1 | Serial data, most significant bit first |
| load_o | output | 1 | One-cycle pulse when a new word is loaded |
| code_o | output | CODE_W (12) | Held converter code |
| mode_o | output | MODE_W (2) | Held power-down mode field |

## Verification
The bench builds the block with its default values: a 16-bit word, a 12-bit code, a 2-bit mode field and a two-stage synchronizer. Each serial phase lasts four system clocks. This keeps every serial edge clear of the synchronizer latency, so a load that is late or missing shows up within a few cycles of the 16th edge. With the fixed word length, the bench can test the 15-versus-16 boundary, a cancel part way through a frame, and extra bits after a complete word. The reserved bits can be set high and checked as dropped.

// File: rtl/serdac_frame_rx.sv
module serdac_frame_rx #(
  parameter int WORD_W = 16,
  parameter int CODE_W = 12,
  parameter int MODE_W = 2,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic              sclk,
  input  logic              sdin,
  output logic              load_o,
  output logic [CODE_W-1:0] code_o,
  output logic [MODE_W-1:0] mode_o
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam int SH_W  = CODE_W + MODE_W - 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [SYNC_N-1:0] f_sy, c_sy, d_sy;
  logic              f_prev, c_prev;
  logic              armed_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [SH_W-1:0]   sh_q;

  wire f_s    = f_sy[SYNC_N-1];
  wire c_s    = c_sy[SYNC_N-1];
  wire d_s    = d_sy[SYNC_N-1];
  wire f_fall = f_prev & ~f_s;
  wire f_rise = ~f_prev & f_s;
  wire c_fall = c_prev & ~c_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      f_sy    <= '1;
      c_sy    <= '1;
      d_sy    <= '0;
      f_prev  <= 1'b1;
      c_prev  <= 1'b1;
      armed_q <= 1'b0;
      cnt_q   <= '0;
      sh_q    <= '0;
      load_o  <= 1'b0;
      code_o  <= '0;
      mode_o  <= '0;
    end else begin
      f_sy   <= {f_sy[SYNC_N-2:0], frame_n};
      c_sy   <= {c_sy[SYNC_N-2:0], sclk};
      d_sy   <= {d_sy[SYNC_N-2:0], sdin};
      f_prev <= f_s;
      c_prev <= c_s;
      load_o <= 1'b0;
      if (f_rise) begin
        armed_q <= 1'b0;
        cnt_q   <= '0;
      end else if (f_fall) begin
        armed_q <= 1'b1;
        cnt_q   <= '0;
      end else if (armed_q && c_fall) begin
        sh_q <= {sh_q[SH_W-2:0], d_s};
        if (cnt_q == LAST) begin
          armed_q <= 1'b0;
          load_o  <= 1'b1;
          code_o  <= {sh_q[CODE_W-2:0], d_s};
          mode_o  <= sh_q[SH_W-1:CODE_W-1];
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/serdac_frame_rx_chk.sv
module serdac_frame_rx_chk #(
  parameter int CODE_W = 12,
  parameter int MODE_W = 2,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_o,
  input logic [CODE_W-1:0] code_o,
  input logic [MODE_W-1:0] mode_o,
  input logic              armed_q,
  input logic [CNT_W-1:0]  cnt_q
);
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!load_o && code_o == '0 && mode_o == '0));

  p_pulse_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> !load_o);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !load_o |-> ($stable(code_o) && $stable(mode_o)));

  p_load_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |-> ($past(armed_q) && $past(cnt_q) == '1));

  p_done_disarms_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |-> !armed_q);
endmodule

bind serdac_frame_rx serdac_frame_rx_chk chk_i (
  .clk(clk), .rst_n(rst_n), .load_o(load_o), .code_o(code_o),
  .mode_o(mode_o), .armed_q(armed_q), .cnt_q(cnt_q)
);

// File: tb/serdac_frame_rx_tb_top.sv
module serdac_frame_rx_tb_top;
  localparam time CLK_P = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_n = 1'b1;
  logic sclk = 1'b1;
  logic sdin = 1'b0;
  logic load_o;
  logic [11:0] code_o;
  logic [1:0] mode_o;

  int tests = 0;
  int fails = 0;
  int loads = 0;
  int dbl = 0;
  logic prev_ld = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  serdac_frame_rx dut_i (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .sclk(sclk), .sdin(sdin),
    .load_o(load_o), .code_o(code_o), .mode_o(mode_o)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (load_o) begin
        loads++;
        if (prev_ld) dbl++;
      end
      prev_ld = load_o;
    end
  end

  localparam logic [15:0] VEC [6] = '{16'hFFFF, 16'h0000, 16'h3ABC,
                                      16'hC123, 16'h1800, 16'h2FFF};

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic frame_lo();
    frame_n = 1'b0;
    tick(4);
  endtask

  task automatic frame_hi();
    frame_n = 1'b1;
    tick(8);
  endtask

  task automatic send_bit(logic b);
    sdin = b;
    tick(4);
    sclk = 1'b0;
    tick(4);
    sdin = ~b;
    tick(2);
    sclk = 1'b1;
    tick(4);
  endtask

  task automatic send_word(logic [15:0] w, int n);
    for (int i = 0; i < n; i++) send_bit(w[15-i]);
    tick(6);
  endtask

  task automatic full_frame(logic [15:0] w);
    frame_lo();
    send_word(w, 16);
    frame_hi();
  endtask

  initial begin
    int base;
    tick(5);
    chk("R1 load in reset", load_o, 0);
    chk("R1 code in reset", code_o, 0);
    rst_n = 1'b1;
    tick(1);
    @(negedge clk);
    chk("R1 load after reset", load_o, 0);
    chk("R1 mode after reset", mode_o, 0);
    tick(4);

    for (int v = 0; v < 6; v++) begin
      base = loads;
      full_frame(VEC[v]);
      chk("R6 one load per frame", loads - base, 1);
      chk("R2 R3 code field", code_o, VEC[v][11:0]);
      chk("R2 mode field", mode_o, VEC[v][13:12]);
    end

    base = loads;
    for (int i = 0; i < 5; i++) send_bit(i[0]);
    tick(6);
    chk("R4 clocks before frame ignored", loads - base, 0);
    full_frame(16'h0555);
    chk("R4 code after stray clocks", code_o, 12'h555);

    base = loads;
    frame_lo();
    send_word(16'h2A5A, 15);
    tick(20);
    chk("R5 no load after 15 bits", loads - base, 0);
    chk("R5 R10 code held at 15", code_o, 12'h555);
    send_bit(1'b1);
    tick(6);
    chk("R5 load after 16th bit", loads - base, 1);
    chk("R5 code after 16th", code_o, 12'hA5B);
    chk("R5 mode after 16th", mode_o, 2'd2);
    frame_hi();

    base = loads;
    frame_lo();
    send_word(16'hFFFF, 10);
    frame_hi();
    chk("R7 abort gives no load", loads - base, 0);
    chk("R7 code unchanged", code_o, 12'hA5B);
    chk("R7 mode unchanged", mode_o, 2'd2);

    base = loads;
    frame_lo();
    send_word(16'h0F0F, 7);
    frame_hi();
    full_frame(16'h1C3E);
    chk("R9 fresh count load", loads - base, 1);
    chk("R9 code after abort", code_o, 12'hC3E);
    chk("R9 mode after abort", mode_o, 2'd1);

    base = loads;
    frame_lo();
    send_word(16'h1234, 16);
    send_word(16'hFFFF, 5);
    chk("R8 extra bits no reload", loads - base, 1);
    chk("R8 code kept", code_o, 12'h234);
    chk("R8 mode kept", mode_o, 2'd1);
    frame_hi();

    chk("R6 pulse one cycle", dbl, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    tests++;
    fails++;
    $display("FAIL R6 watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule